// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

This block tracks which architectural registers of one register file still have a write outstanding. Each register has one pending bit. When an instruction issues, the functional units that will produce its results report their destination registers on per-port set masks, and those bits are raised. When a write port commits a result to the register file, it names the register it wrote, and that bit is dropped. Several write ports can serve the same register file, such as separate ports for individual status-flag fields. Every set mask and every clear request from every port is OR-merged into one set vector and one clear vector, so no port can mask another.

The block also produces the issue stall. Issue stalls when any destination of the incoming instruction is already pending, which is a write-after-write hazard. It also stalls when the external conflict input is high, or when any serialising unit reports busy. The serialising units are load/store, branch, MMU, SPR and trap, and their state-changing work must never overlap. The hazard check reads the current vector. An instruction's own destination bits appear only on the next cycle, so an instruction that reads and writes the same register cannot stall on itself. Issue requests made while stalled are dropped.

Top module: `regpend_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears every pending bit. With no conflict input and no serialising unit busy, `stall_o` is low after reset.
- R2: When `issue_fire_i` is high and `stall_o` is low, the destination bits on `issue_dst_i` are set on `pending_o` from the next clock edge. Bit i of `pending_o` stands for register i.
- R3: Set masks from all write ports in one cycle are OR-merged, so every port's destinations become pending. Port p owns slice `issue_dst_i[p*NREG +: NREG]`.
- R4: A write port p with `wr_en_i[p]` high clears the bit of register `wr_addr_i[p*AW +: AW]` at the next edge. Clears from several ports in one cycle all take effect.
- R5: When a set and a clear reach the same bit in one cycle, the bit ends set.
- R6: `stall_o` is high in any cycle where the OR of all ports' destination masks overlaps `pending_o`. An instruction's own newly set bits do not count before the next cycle.
- R7: `stall_o` is high whenever `conflict_i` is high.
- R8: `stall_o` is high whenever any bit of `serial_busy_i` is high. Bits 0 to 4 stand for load/store, branch, MMU, SPR and trap.
- R9: An issue request made while `stall_o` is high sets no bit, though write-port clears in that cycle still apply.
- R10: A bit that is neither set nor cleared in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_fire_i | input | 1 | Issue attempt this cycle |
| issue_dst_i | input | NWP*NREG | Per-port destination masks of the issuing instruction |
| wr_en_i | input | NWP | Per-port register write completed |
| wr_addr_i | input | NWP*AW | Per-port written register index |
| conflict_i | input | 1 | External issue conflict |
| serial_busy_i | input | NSER | Busy flags of serialising units |
| pending_o | output | NREG | Pending-write vector |
| stall_o | output | 1 | Issue stall |

## Verification
A wrong pending bit shows up at the ports in one of two ways. The bit is visible on `pending_o` one edge after the faulty update. A stuck bit also causes a spurious or missing `stall_o` in the same cycle that a later instruction presents that register as a destination. The bench sweeps every register against every port for the set and clear paths. It checks the merge of simultaneous requests and the set-over-clear case. It also sweeps every destination mask and every conflict and busy combination against `stall_o`.

// File: rtl/rps_pkg.sv
package rps_pkg;
    localparam int DEF_NREG = 8;
    localparam int DEF_NWP  = 3;
    localparam int DEF_NSER = 5;

    typedef struct packed {
        logic waw;
        logic conflict;
        logic serial;
    } stall_cause_t;

    function automatic logic any_cause(input stall_cause_t c);
        return c.waw | c.conflict | c.serial;
    endfunction
endpackage

// File: rtl/rps_merge.sv
module rps_merge #(
    parameter int NREG = rps_pkg::DEF_NREG,
    parameter int NWP  = rps_pkg::DEF_NWP,
    localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [NWP*NREG-1:0] set_req_i,
    input  logic [NWP-1:0]      clr_en_i,
    input  logic [NWP*AW-1:0]   clr_addr_i,
    output logic [NREG-1:0]     set_any_o,
    output logic [NREG-1:0]     clr_any_o
);
    logic [NREG-1:0] clr_dec [NWP];

    for (genvar p = 0; p < NWP; p++) begin : g_dec
        assign clr_dec[p] = clr_en_i[p] ? (NREG'(1) << clr_addr_i[p*AW +: AW]) : '0;
    end

    always_comb begin
        set_any_o = '0;
        clr_any_o = '0;
        for (int p = 0; p < NWP; p++) begin
            set_any_o = set_any_o | set_req_i[p*NREG +: NREG];
            clr_any_o = clr_any_o | clr_dec[p];
        end
    end
endmodule

// File: rtl/rps_vector.sv
module rps_vector #(
    parameter int NREG = rps_pkg::DEF_NREG
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] set_i,
    input  logic [NREG-1:0] clr_i,
    output logic [NREG-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (q_o & ~clr_i) | set_i;
    end

    // R1: cleared out of reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> q_o == '0);
    // R2 / R5: every requested set lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> ((q_o & $past(set_i)) == $past(set_i)));
    // R4: clears without a competing set take effect
    a_r4_clear_lands: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> ((q_o & $past(clr_i & ~set_i)) == '0));
    // R10: untouched bits hold
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> ((q_o & ~$past(set_i | clr_i)) == ($past(q_o) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/rps_stall.sv
module rps_stall #(
    parameter int NREG = rps_pkg::DEF_NREG,
    parameter int NSER = rps_pkg::DEF_NSER
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] pend_i,
    input  logic [NREG-1:0] dst_i,
    input  logic            conflict_i,
    input  logic [NSER-1:0] busy_i,
    output logic            stall_o
);
    import rps_pkg::*;
    stall_cause_t cause;

    always_comb begin
        cause.waw      = |(pend_i & dst_i);
        cause.conflict = conflict_i;
        cause.serial   = |busy_i;
        stall_o        = any_cause(cause);
    end

    a_r6_waw_stall: assert property (@(posedge clk) disable iff (rst)
        (|(pend_i & dst_i)) |-> stall_o);
    a_r7_conflict_stall: assert property (@(posedge clk) disable iff (rst)
        conflict_i |-> stall_o);
    a_r8_serial_stall: assert property (@(posedge clk) disable iff (rst)
        (busy_i != '0) |-> stall_o);
endmodule

// File: rtl/regpend_scoreboard.sv
module regpend_scoreboard #(
    parameter int NREG = rps_pkg::DEF_NREG,
    parameter int NWP  = rps_pkg::DEF_NWP,
    parameter int NSER = rps_pkg::DEF_NSER,
    localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_fire_i,
    input  logic [NWP*NREG-1:0] issue_dst_i,
    input  logic [NWP-1:0]      wr_en_i,
    input  logic [NWP*AW-1:0]   wr_addr_i,
    input  logic                conflict_i,
    input  logic [NSER-1:0]     serial_busy_i,
    output logic [NREG-1:0]     pending_o,
    output logic                stall_o
);
    logic [NREG-1:0] dst_all, clr_all, set_gated;
    logic            issue_ok;

    rps_merge #(.NREG(NREG), .NWP(NWP)) u_merge (
        .set_req_i (issue_dst_i),
        .clr_en_i  (wr_en_i),
        .clr_addr_i(wr_addr_i),
        .set_any_o (dst_all),
        .clr_any_o (clr_all)
    );

    rps_stall #(.NREG(NREG), .NSER(NSER)) u_stall (
        .clk       (clk),
        .rst       (rst),
        .pend_i    (pending_o),
        .dst_i     (dst_all),
        .conflict_i(conflict_i),
        .busy_i    (serial_busy_i),
        .stall_o   (stall_o)
    );

    assign issue_ok  = issue_fire_i & ~stall_o;
    assign set_gated = issue_ok ? dst_all : '0;

    rps_vector #(.NREG(NREG)) u_vec (
        .clk  (clk),
        .rst  (rst),
        .set_i(set_gated),
        .clr_i(clr_all),
        .q_o  (pending_o)
    );

    // R9: a stalled issue adds no bit
    a_r9_stalled_no_set: assert property (@(posedge clk) disable iff (rst)
        (issue_fire_i && stall_o) |=> ((pending_o & ~$past(pending_o)) == '0));
    // R2: an accepted issue raises its destinations
    a_r2_issue_sets: assert property (@(posedge clk) disable iff (rst)
        (issue_fire_i && !stall_o) |=> ((pending_o & $past(dst_all)) == $past(dst_all)));
endmodule

// File: tb/regpend_scoreboard_test.sv
module regpend_scoreboard_test;
    localparam int NREG = 8;
    localparam int NWP  = 3;
    localparam int NSER = 5;
    localparam int AW   = 3;

    logic                clk = 0;
    logic                rst;
    logic                issue_fire_i;
    logic [NWP*NREG-1:0] issue_dst_i;
    logic [NWP-1:0]      wr_en_i;
    logic [NWP*AW-1:0]   wr_addr_i;
    logic                conflict_i;
    logic [NSER-1:0]     serial_busy_i;
    logic [NREG-1:0]     pending_o;
    logic                stall_o;

    int checks = 0, fails = 0;
    logic [NREG-1:0] model;

    always #4 clk = ~clk;

    regpend_scoreboard #(.NREG(NREG), .NWP(NWP), .NSER(NSER)) uut (
        .clk(clk), .rst(rst), .issue_fire_i(issue_fire_i), .issue_dst_i(issue_dst_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .conflict_i(conflict_i),
        .serial_busy_i(serial_busy_i), .pending_o(pending_o), .stall_o(stall_o)
    );

    task automatic chk_pend(string req, logic [NREG-1:0] exp);
        checks++;
        if (pending_o !== exp) begin
            fails++;
            $display("FAIL %s pending actual=%h expected=%h", req, pending_o, exp);
        end
    endtask

    task automatic chk_stall(string req, logic exp);
        checks++;
        if (stall_o !== exp) begin
            fails++;
            $display("FAIL %s stall actual=%b expected=%b", req, stall_o, exp);
        end
    endtask

    task automatic idle();
        issue_fire_i = 0; issue_dst_i = '0; wr_en_i = '0; wr_addr_i = '0;
        conflict_i = 0; serial_busy_i = '0;
    endtask

    // advance one edge; inputs change and are sampled 2 ns after it
    task automatic step();
        @(posedge clk); #2;
    endtask

    initial begin
        #(8 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(); rst = 1;
        step(); step();
        rst = 0; #1;
        chk_pend("R1", '0); chk_stall("R1", 0);

        // R2 / R4: every register through every port, cleared by another port
        for (int r = 0; r < NREG; r++) begin
            for (int p = 0; p < NWP; p++) begin
                int q = (p + 1) % NWP;
                issue_fire_i = 1;
                issue_dst_i = '0;
                issue_dst_i[p*NREG + r] = 1'b1;
                #1 chk_stall("R6 no self stall", 0);
                step(); idle();
                chk_pend("R2", NREG'(1) << r);
                wr_en_i[q] = 1'b1;
                wr_addr_i[q*AW +: AW] = AW'(r);
                step(); idle();
                chk_pend("R4", '0);
            end
        end

        // R3: three ports set in the same cycle
        issue_fire_i = 1;
        issue_dst_i[0*NREG + 1] = 1'b1;
        issue_dst_i[1*NREG + 4] = 1'b1;
        issue_dst_i[2*NREG + 6] = 1'b1;
        step(); idle();
        model = 8'h52;
        chk_pend("R3", model);

        // R4: two ports clear together; R10: bit 4 holds
        wr_en_i = 3'b101;
        wr_addr_i[0*AW +: AW] = 3'd1;
        wr_addr_i[2*AW +: AW] = 3'd6;
        step(); idle();
        model = 8'h10;
        chk_pend("R4 R10", model);

        // R5: set and clear of reg 2 in one cycle
        issue_fire_i = 1;
        issue_dst_i[1*NREG + 2] = 1'b1;
        wr_en_i[0] = 1'b1;
        wr_addr_i[0*AW +: AW] = 3'd2;
        step(); idle();
        model = 8'h14;
        chk_pend("R5", model);

        // R6: every destination mask, on a rotating port
        for (int m = 0; m < 256; m++) begin
            issue_dst_i = '0;
            issue_dst_i[(m % NWP)*NREG +: NREG] = NREG'(m);
            #1 chk_stall("R6", (m & 8'h14) != 0);
        end
        idle();

        // R9: stalled issue with a clear in the same cycle
        issue_fire_i = 1;
        issue_dst_i[0 +: NREG] = 8'h15;
        wr_en_i[2] = 1'b1;
        wr_addr_i[2*AW +: AW] = 3'd2;
        #1 chk_stall("R9 stalled", 1);
        step(); idle();
        model = 8'h10;
        chk_pend("R9", model);

        // R7 / R8: every conflict and busy combination
        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < 32; b++) begin
                conflict_i = c[0];
                serial_busy_i = NSER'(b);
                #1 chk_stall("R7 R8", (c != 0) || (b != 0));
            end
        end

        // R9: issue blocked by a busy serialising unit
        serial_busy_i = 5'b00100;
        issue_fire_i = 1;
        issue_dst_i[NREG + 0] = 1'b1;
        step(); idle();
        chk_pend("R9 serial", model);

        // R1: reset in mid-run
        rst = 1;
        step();
        rst = 0; #1;
        chk_pend("R1 mid-run", '0);
        chk_stall("R1 mid-run", 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule